// File: doc/BRIEF.md
# Interrupt Aggregator with Keyed Soft Reset

This block sits between the event outputs of a serial-peripheral controller core and the processor's interrupt input. Seven single-bit event lines (mode fault, slave-mode fault, transmit queue empty, transmit underrun, receive queue full, receive overrun, transmit queue half empty) are edge-detected and latched into a pending register. A per-source enable register masks the pending bits, and a global enable gates the OR of the masked bits onto one interrupt line.

Software reaches the block through a simple 32-bit register port: a write strobe with address and data, and a combinational read path. Interrupt service reads the pending register and writes the same value back to acknowledge. A fourth register accepts a key. Writing the exact key starts a reset pulse of fixed length for the whole peripheral. The same pulse returns the block's own registers to their defaults.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the registers at 0x1C, 0x20, 0x28 and 0x40 read zero, and `irq_out` and `sw_rst_out` are low.
- R2: A rising edge on `evt_in[i]` sets pending bit i of the register at 0x20. The source-to-bit order is: bit 0 mode fault, 1 slave-mode fault, 2 transmit empty, 3 transmit underrun, 4 receive full, 5 receive overrun, 6 transmit half empty. The bit reads set from the cycle after the clock edge that sampled the edge.
- R3: A write to 0x20 clears each pending bit whose data bit is 1 and leaves the others unchanged. An event line that stays high does not set its bit again after it is cleared.
- R4: When a rising edge and a clearing write hit the same pending bit in the same cycle, the bit stays set.
- R5: `irq_out` is high exactly when bit 31 of the register at 0x1C is set and some pending bit has its enable bit set in the register at 0x28. Pending bits latch whatever the enables are.
- R6: Writing zero to 0x28 holds `irq_out` low while pending bits remain set. Bits 30:0 of 0x1C are not stored.
- R7: Writing exactly 0x0000000A to 0x40 drives `sw_rst_out` high for RST_CYCLES consecutive cycles (default 16), starting the cycle after the write. From that cycle on, the pending, enable and global-enable registers read zero.
- R8: Writing any other value to 0x40 leaves `sw_rst_out` low and all registers unchanged.
- R9: While `sw_rst_out` is high, register writes are ignored, event edges are not latched and `irq_out` is low.
- R10: Reads of 0x40 and of any unmapped address return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_in | input | NUM_SRC | Event lines from the controller core |
| irq_out | output | 1 | Aggregated interrupt request |
| sw_rst_out | output | 1 | Reset pulse for the whole peripheral |

## Verification
The bench targets three corner cases:
- A clearing write that lands in the same cycle as a new edge. A design that lets the clear win drops that interrupt.
- An event held high across an acknowledge. A level-sensitive design re-asserts the bit at once.
- Near-miss reset keys, including a value whose low byte matches the key. A design that decodes only part of the word resets the peripheral.

It also counts the reset pulse cycle by cycle, so an off-by-one counter shows up. It writes during the pulse, so a design that stays writable keeps stale enables after reset. Each single gate on the interrupt path (global enable, per-source enable, pending) is checked on its own so that a missing AND term is seen.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   localparam logic [7:0] OFF_GLOBAL_EN = 8'h1C;
   localparam logic [7:0] OFF_PENDING   = 8'h20;
   localparam logic [7:0] OFF_ENABLE    = 8'h28;
   localparam logic [7:0] OFF_SOFT_RST  = 8'h40;

   localparam int GLOBAL_EN_BIT = 31;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_GLOBAL,
      SEL_PENDING,
      SEL_ENABLE,
      SEL_SOFTRST
   } reg_sel_e;

   function automatic reg_sel_e decode_addr(input logic [31:0] a);
      reg_sel_e s;
      s = SEL_NONE;
      if (a == {24'h0, OFF_GLOBAL_EN}) s = SEL_GLOBAL;
      else if (a == {24'h0, OFF_PENDING}) s = SEL_PENDING;
      else if (a == {24'h0, OFF_ENABLE}) s = SEL_ENABLE;
      else if (a == {24'h0, OFF_SOFT_RST}) s = SEL_SOFTRST;
      return s;
   endfunction

endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
   parameter int NUM_SRC   = 7,
   parameter bit EDGE_MODE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear_all,
   input  logic [NUM_SRC-1:0] evt_in,
   input  logic [NUM_SRC-1:0] ack_mask,
   output logic [NUM_SRC-1:0] pending
);

   logic [NUM_SRC-1:0] set_v;

   generate
      if (EDGE_MODE) begin : g_edge
         logic [NUM_SRC-1:0] evt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) evt_q <= '0;
            else        evt_q <= evt_in;
         end
         assign set_v = evt_in & ~evt_q;
      end else begin : g_level
         assign set_v = evt_in;
      end
   endgenerate

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         pending[i] <= 1'b0;
            else if (clear_all) pending[i] <= 1'b0;
            else if (set_v[i])  pending[i] <= 1'b1;
            else if (ack_mask[i]) pending[i] <= 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
   parameter int NUM_SRC = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear_all,
   input  logic               wr_global,
   input  logic               global_din,
   input  logic               wr_enable,
   input  logic [NUM_SRC-1:0] enable_din,
   output logic               global_en,
   output logic [NUM_SRC-1:0] src_enable
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         global_en <= 1'b0;
      else if (clear_all) global_en <= 1'b0;
      else if (wr_global) global_en <= global_din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         src_enable <= '0;
      else if (clear_all) src_enable <= '0;
      else if (wr_enable) src_enable <= enable_din;
   end

endmodule

// File: rtl/irq_sw_reset.sv
module irq_sw_reset #(
   parameter int RST_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic pulse
);

   localparam int CW = $clog2(RST_CYCLES + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (fire && cnt_q == '0)  cnt_q <= CW'(RST_CYCLES);
      else if (cnt_q != '0)          cnt_q <= cnt_q - 1'b1;
   end

   assign pulse = (cnt_q != '0);

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irq_agg_pkg::*;
#(
   parameter int          NUM_SRC    = 7,
   parameter int          ADDR_W     = 8,
   parameter int          RST_CYCLES = 16,
   parameter logic [31:0] RST_KEY    = 32'h0000_000A,
   parameter bit          EDGE_MODE  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic [NUM_SRC-1:0] evt_in,
   output logic               irq_out,
   output logic               sw_rst_out
);

   generate
      if (NUM_SRC < 1 || NUM_SRC > 31) begin : g_bad_src
         $error("irq_aggregator: NUM_SRC must be 1..31");
      end
      if (ADDR_W < 7 || ADDR_W > 32) begin : g_bad_addr
         $error("irq_aggregator: ADDR_W must be 7..32");
      end
      if (RST_CYCLES < 1) begin : g_bad_rst
         $error("irq_aggregator: RST_CYCLES must be at least 1");
      end
   endgenerate

   localparam int PAD_W = 32 - ADDR_W;

   reg_sel_e           sel;
   logic               wr_ok;
   logic               key_hit;
   logic               clear_all;
   logic [NUM_SRC-1:0] ack_mask;
   logic [NUM_SRC-1:0] pending;
   logic [NUM_SRC-1:0] src_enable;
   logic               global_en;

   generate
      if (PAD_W > 0) begin : g_pad
         assign sel = decode_addr({{PAD_W{1'b0}}, reg_addr});
      end else begin : g_nopad
         assign sel = decode_addr(reg_addr);
      end
   endgenerate

   assign wr_ok     = reg_wr && !sw_rst_out;
   assign key_hit   = wr_ok && (sel == SEL_SOFTRST) && (reg_wdata == RST_KEY);
   assign clear_all = key_hit || sw_rst_out;
   assign ack_mask  = (wr_ok && sel == SEL_PENDING) ? reg_wdata[NUM_SRC-1:0] : '0;

   irq_src_latch #(
      .NUM_SRC   (NUM_SRC),
      .EDGE_MODE (EDGE_MODE)
   ) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_all (clear_all),
      .evt_in    (evt_in),
      .ack_mask  (ack_mask),
      .pending   (pending)
   );

   irq_ctrl_regs #(
      .NUM_SRC (NUM_SRC)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_all  (clear_all),
      .wr_global  (wr_ok && sel == SEL_GLOBAL),
      .global_din (reg_wdata[GLOBAL_EN_BIT]),
      .wr_enable  (wr_ok && sel == SEL_ENABLE),
      .enable_din (reg_wdata[NUM_SRC-1:0]),
      .global_en  (global_en),
      .src_enable (src_enable)
   );

   irq_sw_reset #(
      .RST_CYCLES (RST_CYCLES)
   ) u_swrst (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (key_hit),
      .pulse (sw_rst_out)
   );

   always_comb begin
      reg_rdata = '0;
      case (sel)
         SEL_GLOBAL:  reg_rdata[GLOBAL_EN_BIT] = global_en;
         SEL_PENDING: reg_rdata[NUM_SRC-1:0]   = pending;
         SEL_ENABLE:  reg_rdata[NUM_SRC-1:0]   = src_enable;
         default:     reg_rdata = '0;
      endcase
   end

   assign irq_out = global_en && |(pending & src_enable);

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
   parameter int          NUM_SRC    = 7,
   parameter int          ADDR_W     = 8,
   parameter int          RST_CYCLES = 16,
   parameter logic [31:0] RST_KEY    = 32'h0000_000A,
   parameter bit          EDGE_MODE  = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_wr,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [31:0]        reg_wdata,
   input logic [NUM_SRC-1:0] evt_in,
   input logic               irq_out,
   input logic               sw_rst_out,
   input logic [NUM_SRC-1:0] pending
);

   localparam int RW = $clog2(RST_CYCLES + 2);

   logic [NUM_SRC-1:0] evt_d;
   logic [NUM_SRC-1:0] rise_v;
   logic [RW-1:0]      run_cnt;
   logic               key_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_d <= '0;
      else        evt_d <= evt_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          run_cnt <= '0;
      else if (sw_rst_out) run_cnt <= run_cnt + 1'b1;
      else                 run_cnt <= '0;
   end

   assign rise_v = EDGE_MODE ? (evt_in & ~evt_d) : evt_in;
   assign key_wr = reg_wr && (reg_addr == ADDR_W'(8'h40)) && (reg_wdata == RST_KEY);

   // R2 R4
   event_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_v != '0 && !sw_rst_out && !key_wr) |=> ((pending & $past(rise_v)) == $past(rise_v)));

   // R3
   no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pending & ~$past(pending) & ~$past(rise_v)) == '0));

   // R7
   rst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_rst_out) |-> $past(key_wr));

   // R7
   rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sw_rst_out) |-> ($past(run_cnt) == RW'(RST_CYCLES - 1)));

   // R7
   rst_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst_out |-> (run_cnt < RW'(RST_CYCLES)));

   // R9
   rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst_out |-> (!irq_out && pending == '0));

endmodule

bind irq_aggregator irq_aggregator_chk #(
   .NUM_SRC    (NUM_SRC),
   .ADDR_W     (ADDR_W),
   .RST_CYCLES (RST_CYCLES),
   .RST_KEY    (RST_KEY),
   .EDGE_MODE  (EDGE_MODE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .evt_in     (evt_in),
   .irq_out    (irq_out),
   .sw_rst_out (sw_rst_out),
   .pending    (pending)
);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;

   localparam int NSRC = 7;
   localparam int RSTC = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            reg_wr = 1'b0;
   logic [7:0]      reg_addr = '0;
   logic [31:0]     reg_wdata = '0;
   logic [31:0]     reg_rdata;
   logic [NSRC-1:0] evt_in = '0;
   logic            irq_out;
   logic            sw_rst_out;

   int total = 0;
   int fails = 0;
   bit done  = 0;

   always #5 clk = ~clk;

   irq_aggregator u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .evt_in     (evt_in),
      .irq_out    (irq_out),
      .sw_rst_out (sw_rst_out)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic pulse_evt(input int i);
      @(negedge clk);
      evt_in[i] = 1'b1;
      @(negedge clk);
      evt_in[i] = 1'b0;
   endtask

   task automatic t_reset_state();
      logic [31:0] v;
      rd(8'h1C, v); check("R1 global", v, 0);
      rd(8'h20, v); check("R1 pending", v, 0);
      rd(8'h28, v); check("R1 enable", v, 0);
      rd(8'h40, v); check("R1 softrst", v, 0);
      check("R1 irq", {31'd0, irq_out}, 0);
      check("R1 swrst", {31'd0, sw_rst_out}, 0);
   endtask

   task automatic t_each_source();
      logic [31:0] v;
      for (int i = 0; i < NSRC; i++) begin
         pulse_evt(i);
         rd(8'h20, v); check("R2 bit position", v, 32'h1 << i);
         wr(8'h20, 32'h1 << i);
         rd(8'h20, v); check("R3 ack clears", v, 0);
      end
   endtask

   task automatic t_partial_ack();
      logic [31:0] v;
      pulse_evt(0); pulse_evt(3); pulse_evt(5);
      rd(8'h20, v); check("R2 multiple", v, 32'h29);
      wr(8'h20, 32'h08);
      rd(8'h20, v); check("R3 partial ack", v, 32'h21);
      wr(8'h20, 32'h0);
      rd(8'h20, v); check("R3 zero ack", v, 32'h21);
      wr(8'h20, 32'h21);
      @(negedge clk); evt_in[2] = 1'b1;
      rd(8'h20, v); check("R2 level start", v, 32'h04);
      wr(8'h20, 32'h04);
      rd(8'h20, v); check("R3 held level no reset", v, 0);
      @(negedge clk); evt_in[2] = 1'b0;
   endtask

   task automatic t_collision();
      logic [31:0] v;
      pulse_evt(4);
      @(negedge clk);
      evt_in[4] = 1'b1; reg_wr = 1'b1; reg_addr = 8'h20; reg_wdata = 32'h10;
      @(negedge clk);
      evt_in[4] = 1'b0; reg_wr = 1'b0;
      rd(8'h20, v); check("R4 event beats ack", v, 32'h10);
      wr(8'h20, 32'h10);
      rd(8'h20, v); check("R4 later ack", v, 0);
   endtask

   task automatic t_irq_gating();
      logic [31:0] v;
      pulse_evt(1);
      #1 check("R5 no enables", {31'd0, irq_out}, 0);
      wr(8'h28, 32'h02);
      #1 check("R5 global off", {31'd0, irq_out}, 0);
      wr(8'h1C, 32'h8000_0000);
      #1 check("R5 all on", {31'd0, irq_out}, 1);
      rd(8'h1C, v); check("R5 global readback", v, 32'h8000_0000);
      rd(8'h28, v); check("R5 enable readback", v, 32'h02);
      wr(8'h28, 32'h40);
      #1 check("R5 other source enabled", {31'd0, irq_out}, 0);
      wr(8'h28, 32'h0);
      #1 check("R6 zero enables", {31'd0, irq_out}, 0);
      rd(8'h20, v); check("R6 pending kept", v, 32'h02);
      wr(8'h1C, 32'h7FFF_FFFF);
      rd(8'h1C, v); check("R6 low bits unstored", v, 0);
      wr(8'h28, 32'h02); wr(8'h1C, 32'h8000_0000);
   endtask

   task automatic t_bad_keys();
      logic [31:0] v;
      logic        seen;
      seen = 1'b0;
      wr(8'h40, 32'h0000_000B);
      if (sw_rst_out) seen = 1'b1;
      wr(8'h40, 32'h0000_010A);
      if (sw_rst_out) seen = 1'b1;
      wr(8'h40, 32'h0);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         if (sw_rst_out) seen = 1'b1;
      end
      check("R8 no pulse", {31'd0, seen}, 0);
      rd(8'h28, v); check("R8 enable kept", v, 32'h02);
      rd(8'h20, v); check("R8 pending kept", v, 32'h02);
      check("R8 irq kept", {31'd0, irq_out}, 1);
   endtask

   task automatic t_key_reset();
      logic [31:0] v;
      int n;
      wr(8'h40, 32'h0000_000A);
      n = 0;
      while (sw_rst_out && n < 100) begin
         if (n == 1) begin
            reg_addr = 8'h20; #1 check("R7 pending cleared in pulse", reg_rdata, 0);
         end
         if (n == 2) begin
            reg_wr = 1'b1; reg_addr = 8'h28; reg_wdata = 32'h7F; evt_in[0] = 1'b1;
         end
         if (n == 3) begin
            reg_wr = 1'b0; evt_in[0] = 1'b0;
         end
         if (irq_out) check("R9 irq in pulse", 1, 0);
         n++;
         @(negedge clk);
      end
      check("R7 pulse length", n, RSTC);
      rd(8'h28, v); check("R9 write ignored", v, 0);
      rd(8'h20, v); check("R9 event ignored", v, 0);
      rd(8'h1C, v); check("R7 global cleared", v, 0);
      check("R7 irq cleared", {31'd0, irq_out}, 0);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      wr(8'h28, 32'h7F);
      rd(8'h24, v); check("R10 unmapped", v, 0);
      rd(8'h40, v); check("R10 softrst reads zero", v, 0);
      rd(8'h29, v); check("R10 misaligned", v, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_each_source();
      t_partial_ack();
      t_collision();
      t_irq_gating();
      t_bad_keys();
      t_key_reset();
      t_unmapped();
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

endmodule